// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

The block is a binary up-counter built from identical 4-bit slices joined in a parallel-carry chain. Each slice holds a nibble of the count. It can be forced to zero by an active-low clear or preset from a data word by an active-low load. It advances only when two enables are both high. One enable, `cnt_en`, is shared by every slice and gates counting only. The other, the chain enable, also gates the slice's carry output. Each slice feeds its carry into the chain enable of the next slice, so the whole chain behaves as one wide binary counter. No gates are needed between the slices.

A parameter selects the clear mode. In asynchronous mode the count drops to zero as soon as `clr_n` falls. In synchronous mode `clr_n` is sampled on the rising edge of the clock, like load. A second parameter sets the number of slices. The final carry output can enable a further counter placed outside the block.

Top module: `casc_counter`

## Requirements
- R1: While `clr_n` is low at a rising edge of `clk`, the count is 0 after that edge in both clear modes, whatever `load_n`, `cnt_en` and `chain_en` are.
- R2: In asynchronous clear mode, the count becomes 0 in the same clock cycle in which `clr_n` falls, with no rising edge needed.
- R3: In synchronous clear mode, a fall of `clr_n` between two rising edges leaves the count unchanged until the next rising edge.
- R4: With `clr_n` high and `load_n` low, a rising edge copies `load_val` into `count`, even when both enables are low. Bit i of `load_val` goes to bit i of `count`, which has weight 2^i.
- R5: With `clr_n`, `load_n`, `cnt_en` and `chain_en` all high, each rising edge adds one to the count.
- R6: With `clr_n` and `load_n` high, the count holds if either `cnt_en` or `chain_en` is low.
- R7: An increment from the all-ones count gives 0.
- R8: `carry_out` is high exactly when `chain_en` is high and every count bit is 1. It follows `chain_en` with no clock edge.
- R9: Nibble k of the count (bits 4k+3 down to 4k) advances on an increment only when every lower nibble is 15. The slices together count as one binary number of width 4 x NSTAGE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all changes except an asynchronous clear occur on its rising edge |
| clr_n | input | 1 | Active-low clear, shared by all slices |
| load_n | input | 1 | Active-low parallel load, shared by all slices |
| cnt_en | input | 1 | Count-only enable, shared by all slices |
| chain_en | input | 1 | Carry-gating enable of the lowest slice |
| load_val | input | 4*NSTAGE | Parallel load data |
| count | output | 4*NSTAGE | Current count |
| carry_out | output | 1 | Carry output of the highest slice |

## Verification
Random stimulus mixes clears, loads, increments and holds. Every outcome is compared with an integer model, which separates clear-over-load priority from load-over-enable priority. Directed loads of 0x0FF and 0xFFF show whether the carry ripples correctly across the nibble boundaries and wraps at the top. A load with both enables low shows whether the load is wrongly gated by the enables. While the count is held at all ones, toggling `chain_en` shows whether the carry is combinational or registered. Two instances, one per clear mode, see the same clear pulse that falls mid-cycle. Checking both before the next edge separates an immediate clear from a sampled one.

// File: rtl/cnt_pkg.sv
// Package: shared widths and the clear-mode selector for the counter slices.
// Assumes: every slice is one nibble wide.
package cnt_pkg;
    localparam int SLICE_W = 4;

    typedef logic [SLICE_W-1:0] nib_t;

    // Chooses how the active-low clear reaches the slice registers.
    typedef enum logic {
        CLR_ASYNC = 1'b0,
        CLR_SYNC  = 1'b1
    } clr_mode_e;
endpackage

// File: rtl/cnt_slice_next.sv
// Module: next-state logic of one slice for load and count (the clear is handled by the register).
// Assumes: load_n is active low and wins over step; step is the AND of both enables.
module cnt_slice_next
    import cnt_pkg::*;
(
    input  nib_t q,
    input  nib_t d,
    input  logic load_n,
    input  logic step,
    output nib_t q_nxt
);
    // Pick the preset value, the incremented value or the held value.
    always_comb begin
        if (!load_n) begin
            q_nxt = d;
        end else if (step) begin
            q_nxt = q + nib_t'(1);
        end else begin
            q_nxt = q;
        end
    end
endmodule

// File: rtl/cnt_slice_carry.sv
// Module: combinational carry of one slice, gated by its chain enable.
// Assumes: the carry must follow en_car with no register in the path.
module cnt_slice_carry
    import cnt_pkg::*;
(
    input  nib_t q,
    input  logic en_car,
    output logic carry
);
    // The carry is high when the slice sits at fifteen and its chain enable is high.
    always_comb begin
        carry = en_car & (&q);
    end
endmodule

// File: rtl/cnt_slice.sv
// Module: one 4-bit presettable up-counter slice with a selectable clear mode.
// Assumes: clr_n and load_n are active low; clear beats load; load beats both enables.
module cnt_slice
    import cnt_pkg::*;
#(
    parameter clr_mode_e CLR_MODE = CLR_SYNC
) (
    input  logic clk,
    input  logic clr_n,
    input  logic load_n,
    input  logic en_cnt,
    input  logic en_car,
    input  nib_t d,
    output nib_t q,
    output logic carry
);
    nib_t q_nxt;
    logic step;

    // Counting needs both the shared enable and the chain enable.
    always_comb begin
        step = en_cnt & en_car;
    end

    cnt_slice_next u_next (
        .q      (q),
        .d      (d),
        .load_n (load_n),
        .step   (step),
        .q_nxt  (q_nxt)
    );

    cnt_slice_carry u_carry (
        .q      (q),
        .en_car (en_car),
        .carry  (carry)
    );

    generate
        if (CLR_MODE == CLR_ASYNC) begin : g_async_clr
            // State register; clear acts at once, without the clock.
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n) begin
                    q <= '0;
                end else begin
                    q <= q_nxt;
                end
            end
        end else begin : g_sync_clr
            // State register; clear is sampled on the rising edge, like load.
            always_ff @(posedge clk) begin
                if (!clr_n) begin
                    q <= '0;
                end else begin
                    q <= q_nxt;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/casc_counter.sv
// Module: wide binary counter made of NSTAGE slices in a parallel-carry chain.
// Assumes: all slices share the clock, clear, load and cnt_en. Each slice's carry
// drives the chain enable of the slice above it, and chain_en feeds the lowest slice.
module casc_counter
    import cnt_pkg::*;
#(
    parameter int        NSTAGE   = 3,
    parameter clr_mode_e CLR_MODE = CLR_SYNC,
    localparam int       CNT_W    = SLICE_W * NSTAGE
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic             cnt_en,
    input  logic             chain_en,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             carry_out
);
    logic [NSTAGE:0] chain;

    // The lowest slice takes the external chain enable.
    always_comb begin
        chain[0] = chain_en;
    end

    genvar k;
    generate
        for (k = 0; k < NSTAGE; k++) begin : g_stage
            cnt_slice #(
                .CLR_MODE (CLR_MODE)
            ) u_slice (
                .clk    (clk),
                .clr_n  (clr_n),
                .load_n (load_n),
                .en_cnt (cnt_en),
                .en_car (chain[k]),
                .d      (load_val[k*SLICE_W +: SLICE_W]),
                .q      (count[k*SLICE_W +: SLICE_W]),
                .carry  (chain[k+1])
            );
        end
    endgenerate

    // The carry of the highest slice leaves the block.
    always_comb begin
        carry_out = chain[NSTAGE];
    end
endmodule

// File: rtl/casc_counter_chk.sv
// Module: assertion checker for casc_counter, attached with bind.
// Assumes: clear pulses that fall between rising edges stay low over at least one edge.
module casc_counter_chk #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             clr_n,
    input logic             load_n,
    input logic             cnt_en,
    input logic             chain_en,
    input logic [CNT_W-1:0] load_val,
    input logic [CNT_W-1:0] count,
    input logic             carry_out
);
    // R1
    clr_zero_chk: assert property (@(posedge clk)
        !clr_n |=> (count == '0));

    // R4
    load_copy_chk: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |=> (count == $past(load_val)));

    // R5
    count_inc_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && cnt_en && chain_en) |=> (count == CNT_W'($past(count) + 1'b1)));

    // R6
    count_hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(cnt_en && chain_en)) |=> $stable(count));

    // R8
    carry_chk: assert property (@(posedge clk) disable iff (!clr_n)
        carry_out == (chain_en && (&count)));
endmodule

bind casc_counter casc_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .clr_n     (clr_n),
    .load_n    (load_n),
    .cnt_en    (cnt_en),
    .chain_en  (chain_en),
    .load_val  (load_val),
    .count     (count),
    .carry_out (carry_out)
);

// File: tb/casc_counter_tb.sv
module casc_counter_tb;
    localparam int NSTAGE = 3;
    localparam int CNT_W  = 4 * NSTAGE;
    localparam int MASK   = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             clr_n = 1'b0;
    logic             load_n = 1'b1;
    logic             cnt_en = 1'b0;
    logic             chain_en = 1'b0;
    logic [CNT_W-1:0] load_val = '0;
    logic [CNT_W-1:0] cnt_s, cnt_a;
    logic             car_s, car_a;

    int    checks = 0;
    int    errors = 0;
    int    model  = 0;
    string tag    = "R1";
    bit    done   = 1'b0;

    always #10 clk = ~clk;

    casc_counter #(.NSTAGE(NSTAGE), .CLR_MODE(cnt_pkg::CLR_SYNC)) u_dut (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(cnt_en),
        .chain_en(chain_en), .load_val(load_val), .count(cnt_s), .carry_out(car_s)
    );

    casc_counter #(.NSTAGE(NSTAGE), .CLR_MODE(cnt_pkg::CLR_ASYNC)) u_dut_async (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(cnt_en),
        .chain_en(chain_en), .load_val(load_val), .count(cnt_a), .carry_out(car_a)
    );

    function automatic int next_val(int m, bit c, bit l, bit ce, bit ge, int d);
        if (!c) return 0;
        if (!l) return d & MASK;
        if (ce && ge) return (m + 1) & MASK;
        return m;
    endfunction

    function automatic string op_tag(int m, bit c, bit l, bit ce, bit ge);
        if (!c) return "R1";
        if (!l) return "R4";
        if (!(ce && ge)) return "R6";
        if (m == MASK) return "R7";
        if ((m & 15) == 15) return "R9";
        return "R5";
    endfunction

    // Reference model advances on each rising edge from the applied inputs.
    always @(posedge clk) begin
        tag   <= op_tag(model, clr_n, load_n, cnt_en, chain_en);
        model <= next_val(model, clr_n, load_n, cnt_en, chain_en, int'(load_val));
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_all();
        chk({tag, " sync count"}, int'(cnt_s), model);
        chk({tag, " async count"}, int'(cnt_a), model);
        chk("R8 sync carry", int'(car_s), int'(chain_en && model == MASK));
        chk("R8 async carry", int'(car_a), int'(chain_en && model == MASK));
    endtask

    // Apply inputs just after a falling edge, then check at the next falling edge.
    task automatic cyc(bit c, bit l, bit ce, bit ge, int d);
        clr_n = c; load_n = l; cnt_en = ce; chain_en = ge; load_val = CNT_W'(d);
        #1 chk("R8 sync carry now", int'(car_s), int'(ge && model == MASK));
        @(negedge clk);
        check_all();
    endtask

    // Clear falling mid-cycle, held over one rising edge, with a load pending.
    task automatic mid_clear();
        int held;
        held = model;
        load_n = 1'b0; load_val = CNT_W'(12'h5A5); cnt_en = 1'b1; chain_en = 1'b1;
        #3 clr_n = 1'b0;
        #1;
        chk("R2 async clear immediate", int'(cnt_a), 0);
        chk("R3 sync clear waits edge", int'(cnt_s), held);
        @(negedge clk);
        chk("R1 sync cleared over load", int'(cnt_s), 0);
        chk("R1 async cleared over load", int'(cnt_a), 0);
        #3 clr_n = 1'b1;
        #1 chk("R2 async stays zero after release", int'(cnt_a), 0);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h1A2B3C);
        // Reset state through the clear.
        @(negedge clk);
        @(negedge clk);
        check_all();
        // R4: load with both enables low.
        cyc(1, 0, 0, 0, 12'h0FF);
        // R9: carry ripples across two nibble boundaries.
        cyc(1, 1, 1, 1, 0);
        chk("R9 cascade 0FF->100", int'(cnt_s), 12'h100);
        // R6: each enable alone holds.
        cyc(1, 1, 0, 1, 0);
        cyc(1, 1, 1, 0, 0);
        chk("R6 hold", int'(cnt_a), 12'h100);
        // R8: hold at all ones and toggle the carry-gating enable.
        cyc(1, 0, 0, 0, MASK);
        for (int i = 0; i < 4; i++) begin
            cyc(1, 1, 0, i % 2, 0);
            chk("R8 carry follows chain_en", int'(car_s), i % 2);
            chk("R6 held at all ones", int'(cnt_s), MASK);
        end
        // R7: wrap to zero.
        cyc(1, 1, 1, 1, 0);
        chk("R7 wrap", int'(cnt_s), 0);
        // R5: a few plain increments.
        for (int i = 0; i < 3; i++) cyc(1, 1, 1, 1, 0);
        chk("R5 count three", int'(cnt_s), 3);
        // R2, R3: mid-cycle clear in both modes.
        cyc(1, 0, 0, 0, 12'h3C7);
        mid_clear();
        @(negedge clk);
        check_all();
        // Random mix.
        for (int i = 0; i < 3000; i++) begin
            bit c, l, ce, ge;
            c  = ($urandom % 16) != 0;
            l  = ($urandom % 8) != 0;
            ce = ($urandom % 4) != 0;
            ge = ($urandom % 4) != 0;
            if (($urandom % 64) == 0) begin
                cyc(1, 0, 0, 0, (MASK - 1 - int'($urandom % 3)));
            end else if (($urandom % 200) == 0) begin
                mid_clear();
                @(negedge clk);
                check_all();
            end else begin
                cyc(c, l, ce, ge, int'($urandom) & MASK);
            end
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule